// File: doc/BRIEF.md
# Pipelined Sprite Compositor

The block lays eight hardware sprites over a background pixel stream at a very high dot clock. Instead of gathering all sprite outputs into one wide priority multiplexer, it strings eight identical stages into a line. Each stage registers the pixel it receives and either passes it on or replaces it with its own sprite colour. After the last stage, the pixel that remains is the composited result. The cost of this arrangement is a fixed latency of one cycle per stage. The beam X coordinate and the border flag travel with the pixel, so they leave the block aligned with it.

Sprite bitmap data comes from an external fetcher as delivery records. Each record holds one byte and is tagged with a sprite number and a byte position within the 24-pixel line. The records enter at the head and move one stage per cycle, and a stage keeps only the records addressed to it. A separate return path tells the fetcher, for each sprite, whether the current raster line falls inside that sprite. When it does, the path also gives the byte offset of that line inside the sprite's data, which is the line number times three. The fetcher adds this offset to the sprite's base pointer.

The head of the chain is the stage for sprite 7 and the tail is the stage for sprite 0. Because a later stage overwrites what an earlier one wrote, the lowest-numbered sprite wins. Position, vertical origin, colour and enable are written one sprite at a time through a simple configuration port.

Top module: `sprite_compositor`

## Requirements
- R1: While reset is held and right after it is released, `outPix`, `outX` and `outBorder` are zero and all `reqValid` bits are low.
- R2: When no sprite paints a pixel, `outPix`, `outX` and `outBorder` equal the `bgPix`, `beamX` and `borderIn` presented exactly 8 cycles earlier.
- R3: Where several enabled sprites have a set bit on the same pixel, the colour of the lowest-numbered sprite is output.
- R4: On any pixel presented with `borderIn` high, the output is that pixel's `bgPix`, whatever the sprites hold.
- R5: An enabled sprite whose bit is 1 replaces the pixel with its colour. A bit of 0, or a disabled sprite, leaves the pixel from the sprites behind it, or the background, unchanged.
- R6: The line bitmap is {byte0, byte1, byte2}, with byte0 leftmost. For a sprite at X position sx, pixel x (sx <= x < sx+24) uses bit 23-(x-sx), so each byte is shown MSB first. Pixels outside that 24-pixel window are never painted by the sprite.
- R7: A delivery record with sprite index k (3 bits) and byte index b (2 bits, values 0..2) writes byte b of sprite k's line. Byte index 3 and records for other sprites leave sprite k's line unchanged.
- R8: Records reach every stage, including those far from the head. A stored line stays until it is overwritten, including a line delivered while the sprite was disabled.
- R9: One cycle after `lineY` is applied, `reqValid[k]` is high exactly when sprite k is enabled and sy <= lineY <= sy+20, where sy is its Y origin. In that case `reqOff[6k+5:6k]` = 3*(lineY-sy).
- R10: A configuration write with `cfgSel`=k sets the X position, Y origin, colour and enable of sprite k only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rstN | input | 1 | Asynchronous active-low reset |
| beamX | input | 12 | X coordinate of the incoming pixel |
| lineY | input | 10 | Current raster line, used for line requests |
| bgPix | input | 8 | Background pixel colour |
| borderIn | input | 1 | Pixel lies in the border |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 3 | Sprite addressed by the write |
| cfgEn | input | 1 | Enable value |
| cfgX | input | 12 | X position value |
| cfgY | input | 10 | Y origin value |
| cfgColour | input | 8 | Colour value |
| dlvValid | input | 1 | Delivery record valid |
| dlvSpr | input | 3 | Delivery target sprite |
| dlvByte | input | 2 | Byte position within the line |
| dlvData | input | 8 | Bitmap byte |
| outPix | output | 8 | Composited pixel |
| outX | output | 12 | X coordinate aligned with outPix |
| outBorder | output | 1 | Border flag aligned with outPix |
| reqValid | output | 8 | Per-sprite line request valid |
| reqOff | output | 48 | Per-sprite line byte offset, 6 bits each |

## Verification
On every cycle the assertions check three things at each stage. A disabled stage or a border pixel passes through untouched. A stage's output is either its input or its own colour. A line buffer changes only on a byte write, and at most one byte is written at a time. They also check that a line request never exceeds the last line's offset and falls when a sprite is disabled. Which sprite wins an overlap, the MSB-first bit order within the 24-pixel window, and the discarding of misaddressed records can only be shown by the directed scenarios, which compare whole lines against a priority model. The same holds for delivery to the far stages and the boundary lines of the request window.

// File: rtl/spr_pkg.sv
package spr_pkg;
  localparam int NUM_SPR    = 8;
  localparam int SPR_IDX_W  = $clog2(NUM_SPR);
  localparam int XW         = 12;
  localparam int YW         = 10;
  localparam int PIXW       = 8;
  localparam int HEIGHT     = 21;
  localparam int LINE_BYTES = 3;
  localparam int BYTE_W     = 8;
  localparam int LINE_BITS  = LINE_BYTES * BYTE_W;
  localparam int LINE_W     = $clog2(HEIGHT);
  localparam int OFF_W      = $clog2(HEIGHT * LINE_BYTES);
  localparam int BYTE_IDX_W = 2;
  localparam int CNT_W      = $clog2(LINE_BITS);

  typedef struct packed {
    logic                  valid;
    logic [SPR_IDX_W-1:0]  spr;
    logic [BYTE_IDX_W-1:0] byteSel;
    logic [BYTE_W-1:0]     data;
  } dlv_t;

  typedef struct packed {
    logic [PIXW-1:0] pix;
    logic [XW-1:0]   x;
    logic            border;
  } pix_t;

  typedef struct packed {
    logic [LINE_BYTES-1:0] byteWe;
    logic                  colourWe;
    logic                  start;
    logic                  shift;
    logic                  enabled;
  } strobe_t;
endpackage

// File: rtl/spr_ctrl.sv
module spr_ctrl
  import spr_pkg::*;
#(
  parameter int SPR_ID = 0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWe,
  input  logic [SPR_IDX_W-1:0] cfgSel,
  input  logic                 cfgEn,
  input  logic [XW-1:0]        cfgX,
  input  logic [YW-1:0]        cfgY,
  input  dlv_t                 dlvIn,
  input  logic [XW-1:0]        xIn,
  input  logic [YW-1:0]        lineY,
  output strobe_t              stb,
  output logic                 reqValid,
  output logic [OFF_W-1:0]     reqOff
);
  logic [XW-1:0]    sprX;
  logic [YW-1:0]    sprY;
  logic             en;
  logic [CNT_W-1:0] cnt;
  logic             cfgHit;
  logic             hitStart;
  logic [YW-1:0]    diff;
  logic             inRange;
  logic [OFF_W-1:0] lineOff;

  assign cfgHit   = cfgWe && (cfgSel == SPR_IDX_W'(SPR_ID));
  assign hitStart = en && (xIn == sprX);
  assign diff     = lineY - sprY;
  assign inRange  = en && (lineY >= sprY) && (diff < YW'(HEIGHT));
  assign lineOff  = OFF_W'(diff[LINE_W-1:0]) * OFF_W'(LINE_BYTES);

  always_comb begin
    stb          = '0;
    stb.colourWe = cfgHit;
    stb.start    = hitStart;
    stb.shift    = !hitStart && (cnt != '0);
    stb.enabled  = en;
    for (int b = 0; b < LINE_BYTES; b++) begin
      stb.byteWe[b] = dlvIn.valid && (dlvIn.spr == SPR_IDX_W'(SPR_ID)) &&
                      (dlvIn.byteSel == BYTE_IDX_W'(b));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sprX     <= '0;
      sprY     <= '0;
      en       <= 1'b0;
      cnt      <= '0;
      reqValid <= 1'b0;
      reqOff   <= '0;
    end else begin
      if (cfgHit) begin
        sprX <= cfgX;
        sprY <= cfgY;
        en   <= cfgEn;
      end
      if (hitStart)        cnt <= CNT_W'(LINE_BITS - 1);
      else if (cnt != '0)  cnt <= cnt - 1'b1;
      reqValid <= inRange;
      reqOff   <= inRange ? lineOff : '0;
    end
  end

  p_req_bounds_r9: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (reqOff <= OFF_W'((HEIGHT - 1) * LINE_BYTES)));

  p_req_needs_enable_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && !en) |=> !reqValid);

  p_byte_onehot_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb.byteWe));
endmodule

// File: rtl/spr_datapath.sv
module spr_datapath
  import spr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [PIXW-1:0]   cfgColour,
  input  logic [BYTE_W-1:0] dlvData,
  input  pix_t              pixIn,
  output pix_t              pixOut
);
  logic [PIXW-1:0]      colour;
  logic [LINE_BITS-1:0] lineBuf;
  logic [LINE_BITS-1:0] shReg;
  logic                 curBit;
  logic                 paint;
  pix_t                 pixNext;

  assign curBit = stb.start ? lineBuf[LINE_BITS-1] : shReg[LINE_BITS-1];
  assign paint  = (stb.start || stb.shift) && stb.enabled && curBit && !pixIn.border;

  always_comb begin
    pixNext        = pixIn;
    pixNext.pix    = paint ? colour : pixIn.pix;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colour  <= '0;
      lineBuf <= '0;
      shReg   <= '0;
      pixOut  <= '0;
    end else begin
      if (stb.colourWe) colour <= cfgColour;
      for (int b = 0; b < LINE_BYTES; b++) begin
        if (stb.byteWe[b]) lineBuf[LINE_BITS-1-BYTE_W*b -: BYTE_W] <= dlvData;
      end
      if (stb.start)      shReg <= {lineBuf[LINE_BITS-2:0], 1'b0};
      else if (stb.shift) shReg <= {shReg[LINE_BITS-2:0], 1'b0};
      pixOut <= pixNext;
    end
  end

  p_pass_when_off_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && !stb.enabled) |=> (pixOut == $past(pixIn)));

  p_border_keeps_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && pixIn.border) |=> (pixOut.pix == $past(pixIn.pix)));

  p_paint_is_colour_r5: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> ((pixOut.pix == $past(pixIn.pix)) || (pixOut.pix == $past(colour))));

  p_line_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && (stb.byteWe == '0)) |=> $stable(lineBuf));
endmodule

// File: rtl/sprite_compositor.sv
module sprite_compositor
  import spr_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [XW-1:0]              beamX,
  input  logic [YW-1:0]              lineY,
  input  logic [PIXW-1:0]            bgPix,
  input  logic                       borderIn,
  input  logic                       cfgWe,
  input  logic [SPR_IDX_W-1:0]       cfgSel,
  input  logic                       cfgEn,
  input  logic [XW-1:0]              cfgX,
  input  logic [YW-1:0]              cfgY,
  input  logic [PIXW-1:0]            cfgColour,
  input  logic                       dlvValid,
  input  logic [SPR_IDX_W-1:0]       dlvSpr,
  input  logic [BYTE_IDX_W-1:0]      dlvByte,
  input  logic [BYTE_W-1:0]          dlvData,
  output logic [PIXW-1:0]            outPix,
  output logic [XW-1:0]              outX,
  output logic                       outBorder,
  output logic [NUM_SPR-1:0]         reqValid,
  output logic [NUM_SPR*OFF_W-1:0]   reqOff
);
  dlv_t dlvHead;
  dlv_t dlvStage [NUM_SPR];
  pix_t pixChain [NUM_SPR+1];

  assign dlvHead.valid   = dlvValid;
  assign dlvHead.spr     = dlvSpr;
  assign dlvHead.byteSel = dlvByte;
  assign dlvHead.data    = dlvData;

  assign pixChain[0].pix    = bgPix;
  assign pixChain[0].x      = beamX;
  assign pixChain[0].border = borderIn;

  // Delivery records move one stage per cycle from the head.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SPR; i++) dlvStage[i] <= '0;
    end else begin
      dlvStage[0] <= dlvHead;
      for (int i = 1; i < NUM_SPR; i++) dlvStage[i] <= dlvStage[i-1];
    end
  end

  // Position 0 is the highest-numbered sprite; the tail has sprite 0 (R3).
  for (genvar p = 0; p < NUM_SPR; p++) begin : g_stage
    localparam int SPR = NUM_SPR - 1 - p;
    strobe_t          stb;
    logic             rqV;
    logic [OFF_W-1:0] rqO;

    spr_ctrl #(.SPR_ID(SPR)) u_ctrl (
      .clk      (clk),
      .rstN     (rstN),
      .cfgWe    (cfgWe),
      .cfgSel   (cfgSel),
      .cfgEn    (cfgEn),
      .cfgX     (cfgX),
      .cfgY     (cfgY),
      .dlvIn    (dlvStage[p]),
      .xIn      (pixChain[p].x),
      .lineY    (lineY),
      .stb      (stb),
      .reqValid (rqV),
      .reqOff   (rqO)
    );

    spr_datapath u_dp (
      .clk       (clk),
      .rstN      (rstN),
      .stb       (stb),
      .cfgColour (cfgColour),
      .dlvData   (dlvStage[p].data),
      .pixIn     (pixChain[p]),
      .pixOut    (pixChain[p+1])
    );

    assign reqValid[SPR]              = rqV;
    assign reqOff[SPR*OFF_W +: OFF_W] = rqO;
  end

  assign outPix    = pixChain[NUM_SPR].pix;
  assign outX      = pixChain[NUM_SPR].x;
  assign outBorder = pixChain[NUM_SPR].border;
endmodule

// File: tb/tb_sprite_compositor.sv
module tb_sprite_compositor;
  import spr_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [XW-1:0] beamX = '1;
  logic [YW-1:0] lineY = '0;
  logic [PIXW-1:0] bgPix = '0;
  logic borderIn = 1'b0;
  logic cfgWe = 1'b0;
  logic [SPR_IDX_W-1:0] cfgSel = '0;
  logic cfgEn = 1'b0;
  logic [XW-1:0] cfgX = '0;
  logic [YW-1:0] cfgY = '0;
  logic [PIXW-1:0] cfgColour = '0;
  logic dlvValid = 1'b0;
  logic [SPR_IDX_W-1:0] dlvSpr = '0;
  logic [BYTE_IDX_W-1:0] dlvByte = '0;
  logic [BYTE_W-1:0] dlvData = '0;
  logic [PIXW-1:0] outPix;
  logic [XW-1:0] outX;
  logic outBorder;
  logic [NUM_SPR-1:0] reqValid;
  logic [NUM_SPR*OFF_W-1:0] reqOff;

  int nChecks = 0;
  int nFails = 0;

  int mX [NUM_SPR];
  int mY [NUM_SPR];
  bit mEn [NUM_SPR];
  int mCol [NUM_SPR];
  logic [23:0] mLine [NUM_SPR];
  int expPixArr [0:511];
  int expXArr [0:511];
  int expBrdArr [0:511];

  always #10 clk = ~clk;

  sprite_compositor dut (
    .clk(clk), .rstN(rstN), .beamX(beamX), .lineY(lineY), .bgPix(bgPix),
    .borderIn(borderIn), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgEn(cfgEn),
    .cfgX(cfgX), .cfgY(cfgY), .cfgColour(cfgColour), .dlvValid(dlvValid),
    .dlvSpr(dlvSpr), .dlvByte(dlvByte), .dlvData(dlvData), .outPix(outPix),
    .outX(outX), .outBorder(outBorder), .reqValid(reqValid), .reqOff(reqOff)
  );

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int bgOf(int x);
    return (x * 7 + 3) & 8'hFF;
  endfunction

  function automatic int modelPix(int x, bit brd);
    if (brd) return bgOf(x);
    for (int k = 0; k < NUM_SPR; k++) begin
      if (mEn[k] && x >= mX[k] && x < mX[k] + 24) begin
        if (mLine[k][23 - (x - mX[k])]) return mCol[k];
      end
    end
    return bgOf(x);
  endfunction

  task automatic setSprite(int k, bit en, int x, int y, int col);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = SPR_IDX_W'(k); cfgEn = en;
    cfgX = XW'(x); cfgY = YW'(y); cfgColour = PIXW'(col);
    @(negedge clk);
    cfgWe = 1'b0;
    mEn[k] = en; mX[k] = x; mY[k] = y; mCol[k] = col;
  endtask

  task automatic sendByte(int k, int b, int d);
    @(negedge clk);
    dlvValid = 1'b1; dlvSpr = SPR_IDX_W'(k); dlvByte = BYTE_IDX_W'(b);
    dlvData = BYTE_W'(d);
  endtask

  task automatic loadLine(int k, logic [23:0] bits);
    sendByte(k, 0, bits[23:16]);
    sendByte(k, 1, bits[15:8]);
    sendByte(k, 2, bits[7:0]);
    @(negedge clk);
    dlvValid = 1'b0;
    repeat (12) @(negedge clk);
    mLine[k] = bits;
  endtask

  task automatic runLine(string req, int startX, int count, int bLo, int bHi);
    for (int i = 0; i < count + NUM_SPR; i++) begin
      @(negedge clk);
      if (i >= NUM_SPR) begin
        check(req, int'(outPix), expPixArr[i-NUM_SPR]);
        check(req, int'(outX), expXArr[i-NUM_SPR]);
        check(req, int'(outBorder), expBrdArr[i-NUM_SPR]);
      end
      if (i < count) begin
        int x;
        bit brd;
        x = startX + i;
        brd = (x >= bLo) && (x <= bHi);
        beamX = XW'(x); bgPix = PIXW'(bgOf(x)); borderIn = brd;
        expPixArr[i] = modelPix(x, brd);
        expXArr[i] = x;
        expBrdArr[i] = int'(brd);
      end else begin
        beamX = '1; bgPix = '0; borderIn = 1'b0;
      end
    end
    repeat (30) @(negedge clk);
  endtask

  task automatic checkRequests(string req, int y);
    @(negedge clk);
    lineY = YW'(y);
    repeat (2) @(negedge clk);
    for (int k = 0; k < NUM_SPR; k++) begin
      bit v;
      v = mEn[k] && y >= mY[k] && y <= mY[k] + 20;
      check(req, int'(reqValid[k]), int'(v));
      if (v) check(req, int'(reqOff[k*OFF_W +: OFF_W]), 3 * (y - mY[k]));
    end
  endtask

  task automatic testReset();
    for (int k = 0; k < NUM_SPR; k++) begin
      mEn[k] = 0; mX[k] = 0; mY[k] = 0; mCol[k] = 0; mLine[k] = '0;
    end
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 outPix", int'(outPix), 0);
    check("R1 reqValid", int'(reqValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 outPix", int'(outPix), 0);
    check("R1 outX", int'(outX), 0);
    check("R1 outBorder", int'(outBorder), 0);
    check("R1 reqValid", int'(reqValid), 0);
  endtask

  task automatic testPassThrough();
    runLine("R2 passthrough", 0, 60, 20, 25);
  endtask

  task automatic testSingle();
    loadLine(0, 24'hA50F81);
    setSprite(0, 1'b1, 10, 50, 8'h11);
    runLine("R5 R6 single sprite", 0, 50, 999, 999);
  endtask

  task automatic testOverlap();
    loadLine(2, 24'hFFFFFF);
    setSprite(2, 1'b1, 12, 70, 8'h22);
    loadLine(5, 24'hFFFFFF);
    setSprite(5, 1'b1, 20, 0, 8'h55);
    runLine("R3 priority", 0, 80, 999, 999);
  endtask

  task automatic testBorder();
    runLine("R4 border", 0, 80, 14, 30);
  endtask

  task automatic testDelivery();
    sendByte(0, 3, 8'h00);
    loadLine(3, 24'hF0000F);
    runLine("R7 misaddressed records", 0, 80, 999, 999);
    setSprite(3, 1'b1, 60, 100, 8'h33);
    runLine("R8 far stage delivery", 0, 100, 999, 999);
  endtask

  task automatic testConfig();
    setSprite(5, 1'b1, 40, 0, 8'h66);
    setSprite(2, 1'b0, 12, 70, 8'h22);
    runLine("R10 per-sprite config", 0, 100, 999, 999);
  endtask

  task automatic testRequests();
    checkRequests("R9 first line", 50);
    checkRequests("R9 last line", 70);
    checkRequests("R9 past last", 71);
    checkRequests("R9 before first", 69);
    checkRequests("R9 low sprite", 10);
    checkRequests("R9 far sprite", 120);
    checkRequests("R9 far past", 121);
  endtask

  bit done = 0;

  initial begin
    testReset();
    testPassThrough();
    testSingle();
    testOverlap();
    testBorder();
    testDelivery();
    testRequests();
    testConfig();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog all requirements actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule